// File: doc/BRIEF.md
# Extended 8-bit ALU with Multiplier

This block is the arithmetic unit of a small accumulator-based controller datapath. It takes a working-register value, a second operand and the current carry flag, and performs one of a set of already decoded operations. Addition comes with and without carry-in. Subtraction comes in two directions: the second operand minus the working register, and the working register minus the second operand. The second operand is either a file-register value or an instruction literal. There is also a two's-complement negate and an unsigned 8x8 multiply.

Every subtract treats the carry flag as an active-low borrow: C=1 means "no borrow". Because of this, a wide subtraction can be built by chaining byte operations, starting from the low byte. The multiply finishes in one cycle. It writes a separate 16-bit product pair and does not touch the byte result or the flags.

All results are computed combinationally. They are captured into output registers on the rising clock edge when `en_i` is high. The destination select records whether the host should write the byte result back to the working register or to the file register.

Top module: `acc_alu_ext`

## Requirements
- R1: After the asynchronous active-low reset, `result_o`, `prod_o`, `dest_f_o` and all five flags are zero.
- R2: `op_i`=0 (add) stores operand+W. `op_i`=1 (add with carry) stores operand+W+`c_i`. For both, C is the carry out of bit 7 and DC is the carry out of bit 3.
- R3: `op_i`=2 stores operand−W. `op_i`=3 stores operand−W−(1−`c_i`). For both, C=1 when no borrow occurred and DC=1 when the low nibble needed no borrow.
- R4: `op_i`=4 (reverse subtract with borrow) stores W−operand−(1−`c_i`), with C and DC following the same no-borrow convention as R3.
- R5: `op_i`=5 (negate) stores (operand XOR 0xFF)+1. C=1 only for operand 0x00, DC=1 only when the operand's low nibble is 0, and OV=1 only for operand 0x80.
- R6: For every byte-result operation, N equals bit 7 of the result and Z is 1 exactly when the result is 0. OV is 1 exactly when the signed value of the operation falls outside −128..127.
- R7: `op_i`=6 stores the unsigned product W×operand in `prod_o` (high byte in bits 15:8). `result_o`, the flags and `dest_f_o` keep their values.
- R8: When `en_i` is 0, or `op_i`=7, no output changes at the clock edge.
- R9: Byte-result operations other than negate copy `dest_i` to `dest_f_o` (0 = working register, 1 = file register). Negate always sets `dest_f_o` to 1.
- R10: Two reverse subtracts chain into a correct 16-bit difference. The first works on the low bytes with `c_i`=1. The second works on the high bytes with `c_i` taken from the first result's C.
- R11: The operand is `lit_i` when `use_lit_i`=1 and `f_i` otherwise. This holds for every operation, including multiply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Capture enable for results and flags |
| op_i | input | 3 | Decoded operation code |
| w_i | input | 8 | Working register value |
| f_i | input | 8 | File register operand |
| lit_i | input | 8 | Literal operand |
| use_lit_i | input | 1 | Selects the literal as the operand |
| c_i | input | 1 | Current carry flag (carry-in / inverted borrow) |
| dest_i | input | 1 | Requested destination: 0 working register, 1 file register |
| result_o | output | 8 | Registered byte result |
| dest_f_o | output | 1 | Registered destination select |
| n_o | output | 1 | Negative flag |
| ov_o | output | 1 | Signed overflow flag |
| c_o | output | 1 | Carry / no-borrow flag |
| dc_o | output | 1 | Nibble carry flag |
| z_o | output | 1 | Zero flag |
| prod_o | output | 16 | Registered product pair |

## Verification
The bench builds the block with `DATA_W`=8 and `MUL_ARRAY`=1. With these values the multiply is built as the generated shift-and-add partial-product array rather than the plain operator form. Full 8-bit operands then reach that array's extremes, such as 0xFF×0xFF, and every partial-product row is exercised.

The 8-bit width also puts the nibble-carry boundary and the signed extremes within reach of directed vectors: 0x7F+1, operand 0x80 under negate, and borrow chains across a 16-bit pair. Random vectors mix all eight codes, both operand sources and disabled cycles.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_ADDC  = 3'd1,
    OP_SUB   = 3'd2,
    OP_SUBB  = 3'd3,
    OP_RSUBB = 3'd4,
    OP_NEG   = 3'd5,
    OP_MUL   = 3'd6,
    OP_RSV   = 3'd7
  } alu_op_e;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int W    = 8,
  parameter int HALF = W / 2
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         hc_o,
  output logic         ov_o
);
  localparam int HI_W = W - HALF;

  logic [HALF:0] lo_sum;
  logic [HI_W:0] hi_sum;

  // split at the nibble boundary so the half carry is a real adder output
  assign lo_sum = {1'b0, a_i[HALF-1:0]} + {1'b0, b_i[HALF-1:0]} + {{HALF{1'b0}}, cin_i};
  assign hi_sum = {1'b0, a_i[W-1:HALF]} + {1'b0, b_i[W-1:HALF]} + {{HI_W{1'b0}}, lo_sum[HALF]};

  assign sum_o  = {hi_sum[HI_W-1:0], lo_sum[HALF-1:0]};
  assign cout_o = hi_sum[HI_W];
  assign hc_o   = lo_sum[HALF];
  assign ov_o   = (a_i[W-1] == b_i[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/acc_alu_mul.sv
module acc_alu_mul #(
  parameter int W     = 8,
  parameter bit ARRAY = 1'b0
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  localparam int PW = 2 * W;

  generate
    if (ARRAY) begin : g_array
      logic [PW-1:0] row [W];
      for (genvar i = 0; i < W; i++) begin : g_row
        assign row[i] = b_i[i] ? ({{W{1'b0}}, a_i} << i) : '0;
      end
      always_comb begin
        p_o = '0;
        for (int k = 0; k < W; k++) p_o = p_o + row[k];
      end
    end else begin : g_op
      assign p_o = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
    end
  endgenerate
endmodule

// File: rtl/acc_alu_ext.sv
module acc_alu_ext
  import acc_alu_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter bit MUL_ARRAY = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [2:0]          op_i,
  input  logic [DATA_W-1:0]   w_i,
  input  logic [DATA_W-1:0]   f_i,
  input  logic [DATA_W-1:0]   lit_i,
  input  logic                use_lit_i,
  input  logic                c_i,
  input  logic                dest_i,
  output logic [DATA_W-1:0]   result_o,
  output logic                dest_f_o,
  output logic                n_o,
  output logic                ov_o,
  output logic                c_o,
  output logic                dc_o,
  output logic                z_o,
  output logic [2*DATA_W-1:0] prod_o
);
  localparam int PW = 2 * DATA_W;

  alu_op_e             op;
  logic [DATA_W-1:0]   opnd;
  logic [DATA_W-1:0]   add_a, add_b, add_sum;
  logic                add_cin, add_cout, add_hc, add_ov;
  logic [PW-1:0]       prod_d;
  logic                byte_op, mul_op;

  assign op      = alu_op_e'(op_i);
  assign opnd    = use_lit_i ? lit_i : f_i;
  assign mul_op  = (op == OP_MUL);
  assign byte_op = !mul_op && (op != OP_RSV);

  // every byte op maps onto a + b + cin; subtraction adds the complement
  always_comb begin
    add_a   = opnd;
    add_b   = w_i;
    add_cin = 1'b0;
    unique case (op)
      OP_ADD:   ;
      OP_ADDC:  add_cin = c_i;
      OP_SUB:   begin add_b = ~w_i;  add_cin = 1'b1; end
      OP_SUBB:  begin add_b = ~w_i;  add_cin = c_i;  end
      OP_RSUBB: begin add_a = w_i;   add_b = ~opnd; add_cin = c_i; end
      OP_NEG:   begin add_a = ~opnd; add_b = '0;    add_cin = 1'b1; end
      default:  ;
    endcase
  end

  acc_alu_addsub #(.W(DATA_W)) u_addsub (
    .a_i    (add_a),
    .b_i    (add_b),
    .cin_i  (add_cin),
    .sum_o  (add_sum),
    .cout_o (add_cout),
    .hc_o   (add_hc),
    .ov_o   (add_ov)
  );

  acc_alu_mul #(.W(DATA_W), .ARRAY(MUL_ARRAY)) u_mul (
    .a_i (w_i),
    .b_i (opnd),
    .p_o (prod_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      dest_f_o <= 1'b0;
      n_o      <= 1'b0;
      ov_o     <= 1'b0;
      c_o      <= 1'b0;
      dc_o     <= 1'b0;
      z_o      <= 1'b0;
      prod_o   <= '0;
    end else if (en_i) begin
      if (mul_op) begin
        prod_o <= prod_d;
      end else if (byte_op) begin
        result_o <= add_sum;
        dest_f_o <= (op == OP_NEG) ? 1'b1 : dest_i;
        n_o      <= add_sum[DATA_W-1];
        ov_o     <= add_ov;
        c_o      <= add_cout;
        dc_o     <= add_hc;
        z_o      <= (add_sum == '0);
      end
    end
  end

  AST_MUL_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mul_op) |=> ($stable({n_o, ov_o, c_o, dc_o, z_o}) && $stable(result_o) && $stable(dest_f_o))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || op == OP_RSV) |=> ($stable(result_o) && $stable(prod_o) && $stable({n_o, ov_o, c_o, dc_o, z_o}))); // R8
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && byte_op) |=> (z_o == (result_o == '0))); // R6
  AST_NEG_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && byte_op) |=> (n_o == result_o[DATA_W-1])); // R6
  AST_NEG_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op == OP_NEG) |=> dest_f_o); // R9
  AST_NEG_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op == OP_NEG) |=> (c_o == (result_o == '0))); // R5
  AST_PROD_ONLY_MUL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && byte_op) |=> $stable(prod_o)); // R7
endmodule

// File: tb/acc_alu_ext_tb_top.sv
`timescale 1ns/1ps
module acc_alu_ext_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [2:0]  op;
  logic [7:0]  w, f, lit;
  logic        use_lit, cin, dest;
  logic [7:0]  result;
  logic        dest_f, n, ov, c, dc, z;
  logic [15:0] prod;

  int n_vec = 0;
  int n_bad = 0;

  logic [7:0]  e_res;
  logic        e_dest, e_n, e_ov, e_c, e_dc, e_z;
  logic [15:0] e_prod;

  always #2.5 clk = ~clk;

  acc_alu_ext #(.DATA_W(8), .MUL_ARRAY(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .op_i(op), .w_i(w), .f_i(f),
    .lit_i(lit), .use_lit_i(use_lit), .c_i(cin), .dest_i(dest),
    .result_o(result), .dest_f_o(dest_f), .n_o(n), .ov_o(ov), .c_o(c),
    .dc_o(dc), .z_o(z), .prod_o(prod)
  );

  function automatic string auto_tag(input logic [2:0] o, input logic e);
    if (!e || o == 3'd7) return "R8";
    case (o)
      3'd0, 3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4:       return "R4";
      3'd5:       return "R5";
      default:    return "R7";
    endcase
  endfunction

  // reference model built from the requirement arithmetic
  task automatic model(input logic e, input logic [2:0] o, input logic [7:0] wv,
                       input logic [7:0] fv, input logic [7:0] lv, input logic ul,
                       input logic cv, input logic dv);
    int x, y, bor, r, s;
    logic [7:0] opv;
    opv = ul ? lv : fv;
    if (!e || o == 3'd7) return;
    if (o == 3'd6) begin
      e_prod = 16'(int'(wv) * int'(opv));
      return;
    end
    bor = cv ? 0 : 1;
    case (o)
      3'd0, 3'd1: begin
        y = (o == 3'd1) ? int'(cv) : 0;
        r = int'(opv) + int'(wv) + y;
        e_c  = (r > 255);
        e_dc = ((int'(opv) % 16) + (int'(wv) % 16) + y) > 15;
        s = int'($signed(opv)) + int'($signed(wv)) + y;
      end
      3'd2, 3'd3, 3'd4: begin
        if (o == 3'd2) bor = 0;
        x = (o == 3'd4) ? int'(wv) : int'(opv);
        y = (o == 3'd4) ? int'(opv) : int'(wv);
        r = x - y - bor;
        e_c  = (x >= y + bor);
        e_dc = ((x % 16) >= (y % 16) + bor);
        s = (o == 3'd4) ? int'($signed(wv)) - int'($signed(opv)) - bor
                        : int'($signed(opv)) - int'($signed(wv)) - bor;
      end
      default: begin
        r = 256 - int'(opv);
        e_c  = (opv == 8'h00);
        e_dc = (opv[3:0] == 4'h0);
        s = -int'($signed(opv));
      end
    endcase
    e_res  = 8'(r);
    e_ov   = (s > 127) || (s < -128);
    e_n    = e_res[7];
    e_z    = (e_res == 8'h00);
    e_dest = (o == 3'd5) ? 1'b1 : dv;
  endtask

  task automatic check(input string tag);
    n_vec++;
    if ({result, dest_f, n, ov, c, dc, z, prod} !== {e_res, e_dest, e_n, e_ov, e_c, e_dc, e_z, e_prod}) begin
      n_bad++;
      $display("FAIL %s: got res=%h dest=%b nvcdz=%b%b%b%b%b prod=%h exp res=%h dest=%b nvcdz=%b%b%b%b%b prod=%h",
               tag, result, dest_f, n, ov, c, dc, z, prod,
               e_res, e_dest, e_n, e_ov, e_c, e_dc, e_z, e_prod);
    end
  endtask

  // drive at the falling edge, capture on the rising edge, compare at the next falling edge
  task automatic apply(input logic e, input logic [2:0] o, input logic [7:0] wv,
                       input logic [7:0] fv, input logic [7:0] lv, input logic ul,
                       input logic cv, input logic dv, input string tag);
    en = e; op = o; w = wv; f = fv; lit = lv; use_lit = ul; cin = cv; dest = dv;
    model(e, o, wv, fv, lv, ul, cv, dv);
    @(negedge clk);
    check(tag == "" ? auto_tag(o, e) : tag);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; en = 1'b0; op = '0; w = '0; f = '0; lit = '0;
    use_lit = 1'b0; cin = 1'b0; dest = 1'b0;
    e_res = '0; e_dest = 0; e_n = 0; e_ov = 0; e_c = 0; e_dc = 0; e_z = 0; e_prod = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    apply(1, 3'd0, 8'h01, 8'hFF, 8'h00, 0, 0, 0, "R2");    // wraps to 0: C, DC, Z
    apply(1, 3'd0, 8'h01, 8'h7F, 8'h00, 0, 0, 1, "R6");    // signed overflow
    apply(1, 3'd1, 8'h0F, 8'h00, 8'h00, 0, 1, 0, "R2");    // carry-in into nibble
    apply(1, 3'd2, 8'h5A, 8'h5A, 8'h00, 0, 0, 1, "R3");    // equal: no borrow, zero
    apply(1, 3'd3, 8'h00, 8'h00, 8'h00, 0, 0, 0, "R3");    // borrow in only
    apply(1, 3'd4, 8'h80, 8'h01, 8'h00, 0, 1, 0, "R4");    // signed overflow on reverse
    apply(1, 3'd5, 8'h00, 8'h00, 8'h00, 0, 0, 0, "R5");
    apply(1, 3'd5, 8'h00, 8'h80, 8'h00, 0, 0, 0, "R5");
    apply(1, 3'd5, 8'h00, 8'h01, 8'h00, 0, 0, 0, "R9");
    apply(1, 3'd4, 8'h34, 8'h56, 8'h00, 0, 1, 1, "R10");   // low byte of 0x1234-0x0456
    apply(1, 3'd4, 8'h12, 8'h04, 8'h00, 0, e_c, 1, "R10"); // high byte
    if ({result, e_res} !== 16'h0D0D) begin
      n_vec++; n_bad++;
      $display("FAIL R10: got high=%h exp 0d", result);
    end
    apply(1, 3'd6, 8'hFF, 8'hFF, 8'h00, 0, 0, 0, "R7");
    apply(1, 3'd6, 8'h0C, 8'h00, 8'h0B, 1, 1, 1, "R11");
    apply(1, 3'd0, 8'h10, 8'hEE, 8'h22, 1, 0, 1, "R11");
    apply(0, 3'd0, 8'h99, 8'h99, 8'h00, 0, 1, 0, "R8");
    apply(1, 3'd7, 8'h99, 8'h99, 8'h00, 0, 1, 0, "R8");
    apply(1, 3'd6, 8'h80, 8'h00, 8'h00, 0, 0, 0, "R7");    // zero product, flags untouched

    for (int i = 0; i < 400; i++) begin
      apply(($urandom_range(0, 9) != 0), 3'($urandom_range(0, 7)),
            8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), "");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule